// File: doc/BRIEF.md
# Three-Line Serial Configuration Register File

The block takes configuration words from a one-way serial bus with three inputs: a data line, a bit clock and an enable that is active low. While the enable is low, each rising edge of the bit clock moves one data bit into a shift register, most significant bit first. When the enable returns high, the finished frame is moved into the reference-clock domain. There its trailing address field selects one of several configuration latches, and its leading data field is written into that latch.

The block never counts bits. Only the newest 21 bits in the shift register are used. Bits shifted in earlier fall off the top of the register, and a short frame keeps the older bits from the previous frame.

A captured frame is not written straight away. It waits until the divider side raises `div_safe`, which marks a point in the divider cycle where no ratio is being read. The write then happens, and a single-cycle update strobe for the written latch tells the consumer that new contents have arrived. One latch also supplies the ratio code between fast-mode and normal charge-pump current.

Top module: `sprog_top`

## Requirements
- R1: While `ser_en_n` is low, each rising edge of `ser_clk` shifts `ser_data` into bit 0 of the 21-bit shift register, and the older bits move one place toward the MSB.
- R2: Rising edges of `ser_clk` while `ser_en_n` is high leave the shift register unchanged.
- R3: A commit uses the last 21 bits shifted in, whatever the number of `ser_clk` pulses. Extra leading bits are dropped, and a short frame keeps older bits from before it.
- R4: In the 21-bit word, the first bit received is the data MSB. The first 17 bits are data (word bits 20..4), and the last 4 bits are the address (word bits 3..0, address MSB received first).
- R5: A rising edge of `ser_en_n` commits the word. Address 2+k writes latch k (k = 0..5), which appears on `cfg_bus[k*17 +: 17]`.
- R6: A commit to address 0, 1 or 8..15 produces no strobe and changes no latch.
- R7: A commit is written only in a cycle where `div_safe` is high. Until then it is held, and a newer commit replaces a held one.
- R8: `cfg_upd[k]` is high for exactly one cycle, the cycle after latch k is written. At most one strobe bit is high at a time.
- R9: After reset all latches read zero, and `cfg_valid` and `cfg_upd` are zero.
- R10: `cfg_valid[k]` goes high on the first write to latch k and stays high until reset.
- R11: `pump_ratio` equals bits 2..0 of latch 0 (the data field at address 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that the latches use |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial bit clock, sampled on its rising edge |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge commits the frame |
| div_safe | input | 1 | High when the dividers are not reading their ratios |
| cfg_bus | output | 102 | Six 17-bit latches, latch k at bits k*17 and up |
| cfg_valid | output | 6 | Per-latch flag that a latch has been written |
| cfg_upd | output | 6 | One-cycle update strobe for each latch |
| pump_ratio | output | 3 | Fast-to-normal charge-pump current ratio code |

## Verification
The bench builds the block with its default parameters: 17 data bits, a 4-bit address and six latches starting at address 2. At that size every one of the 16 addresses can be swept, so each latch is written and each unused address is shown to be ignored. All eight pump-ratio codes can also be driven. A shift model in the bench computes the expected word for frames that are too long, frames that are too short and bit-clock toggling while the enable is high. A window with `div_safe` held low shows that a commit waits and is then written.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam int unsigned DATA_W_DEF = 17;
  localparam int unsigned ADDR_W_DEF = 4;
  localparam int unsigned NUM_DEF    = 6;
  localparam int unsigned BASE_DEF   = 2;
  localparam int unsigned PUMP_W_DEF = 3;
endpackage

// File: rtl/sprog_shift.sv
module sprog_shift #(
  parameter int unsigned W = 21
) (
  input  logic         ser_clk,
  input  logic         rst_n,
  input  logic         ser_en_n,
  input  logic         ser_data,
  output logic [W-1:0] word
);
  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else if (!ser_en_n) word <= {word[W-2:0], ser_data};
  end

  // R1: one-place shift with the new bit at the LSB
  a_r1_shift_in: assert property (@(posedge ser_clk) disable iff (!rst_n)
    !ser_en_n |=> (word[W-1:1] == $past(word[W-2:0])) && (word[0] == $past(ser_data)));
  // R2: bit clock ignored while the enable is high
  a_r2_idle_hold: assert property (@(posedge ser_clk) disable iff (!rst_n)
    ser_en_n |=> $stable(word));
endmodule

// File: rtl/sprog_edge.sv
module sprog_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic s1, s2, s3;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end
  assign rise = s2 & ~s3;

  // R5: a commit edge lasts one cycle
  a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/sprog_bank.sv
module sprog_bank #(
  parameter int unsigned DATA_W = 17,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NUM    = 6,
  parameter int unsigned BASE   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [DATA_W+ADDR_W-1:0] word_in,
  input  logic                     div_safe,
  output logic [NUM*DATA_W-1:0]    regs,
  output logic [NUM-1:0]           valid,
  output logic [NUM-1:0]           upd
);
  localparam int unsigned WW = DATA_W + ADDR_W;

  logic          pend;
  logic [WW-1:0] pword;
  logic          fire;

  assign fire = pend & div_safe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      pword <= '0;
    end else if (load) begin
      pend  <= 1'b1;
      pword <= word_in;
    end else if (fire) begin
      pend  <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM; k++) begin : g_latch
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE + k);
    logic sel;
    assign sel = fire && (pword[ADDR_W-1:0] == MY_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[k*DATA_W +: DATA_W] <= '0;
        valid[k]                 <= 1'b0;
        upd[k]                   <= 1'b0;
      end else begin
        upd[k] <= sel;
        if (sel) begin
          regs[k*DATA_W +: DATA_W] <= pword[WW-1:ADDR_W];
          valid[k]                 <= 1'b1;
        end
      end
    end

    // R8: latch contents move only together with their strobe
    a_r8_change_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (regs[k*DATA_W +: DATA_W] != $past(regs[k*DATA_W +: DATA_W])) |-> upd[k]);
    // R10: the written flag is sticky
    a_r10_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(valid[k]) |-> valid[k]);
  end

  // R8: never more than one strobe
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(upd));
  // R7: writes happen only in a safe cycle
  a_r7_safe_only: assert property (@(posedge clk) disable iff (!rst_n)
    (|upd) |-> $past(div_safe));
endmodule

// File: rtl/sprog_top.sv
module sprog_top #(
  parameter int unsigned DATA_W = sprog_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W = sprog_pkg::ADDR_W_DEF,
  parameter int unsigned NUM    = sprog_pkg::NUM_DEF,
  parameter int unsigned BASE   = sprog_pkg::BASE_DEF,
  parameter int unsigned PUMP_W = sprog_pkg::PUMP_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_data,
  input  logic                  ser_clk,
  input  logic                  ser_en_n,
  input  logic                  div_safe,
  output logic [NUM*DATA_W-1:0] cfg_bus,
  output logic [NUM-1:0]        cfg_valid,
  output logic [NUM-1:0]        cfg_upd,
  output logic [PUMP_W-1:0]     pump_ratio
);
  localparam int unsigned WW = DATA_W + ADDR_W;

  logic [WW-1:0] sword;
  logic          commit;

  sprog_shift #(.W(WW)) i_shift (
    .ser_clk (ser_clk),
    .rst_n   (rst_n),
    .ser_en_n(ser_en_n),
    .ser_data(ser_data),
    .word    (sword)
  );

  sprog_edge i_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ser_en_n),
    .rise    (commit)
  );

  sprog_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM(NUM), .BASE(BASE)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (commit),
    .word_in (sword),
    .div_safe(div_safe),
    .regs    (cfg_bus),
    .valid   (cfg_valid),
    .upd     (cfg_upd)
  );

  assign pump_ratio = cfg_bus[PUMP_W-1:0];
endmodule

// File: tb/test_sprog_top.sv
module test_sprog_top;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_en_n = 1'b1, div_safe = 1'b1;
  logic [101:0] cfg_bus;
  logic [5:0]   cfg_valid, cfg_upd;
  logic [2:0]   pump_ratio;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [20:0]  model_sr = '0;
  logic [101:0] exp_bus = '0;
  logic [5:0]   exp_valid = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprog_top i_sprog_top (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_en_n(ser_en_n), .div_safe(div_safe), .cfg_bus(cfg_bus),
    .cfg_valid(cfg_valid), .cfg_upd(cfg_upd), .pump_ratio(pump_ratio)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input int n, input logic [63:0] bits);
    ser_en_n = 1'b0;
    #SH;
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      #SH; ser_clk = 1'b1;
      model_sr = {model_sr[19:0], bits[i]};
      #SH; ser_clk = 1'b0;
    end
    #SH; ser_en_n = 1'b1;
  endtask

  task automatic commit_check(input string tag);
    logic [3:0]  a = model_sr[3:0];
    logic [16:0] d = model_sr[20:4];
    logic [5:0]  got = '0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if ((|cfg_upd) && got == 0) begin
        got = cfg_upd;
        @(negedge clk);
        chk(cfg_upd == 0, {tag, " R8 strobe one cycle"}, 128'(cfg_upd), 128'(0));
      end
    end
    if (a >= 2 && a < 8) begin
      chk(got == 6'(1 << (a - 2)), {tag, " R5 strobe select"}, 128'(got), 128'(1 << (a - 2)));
      exp_bus[(a - 2)*17 +: 17] = d;
      exp_valid[a - 2] = 1'b1;
    end else begin
      chk(got == 0, {tag, " R6 unused address no strobe"}, 128'(got), 128'(0));
    end
    chk(cfg_bus == exp_bus, {tag, " R4 latch contents"}, 128'(cfg_bus), 128'(exp_bus));
    chk(cfg_valid == exp_valid, {tag, " R10 valid flags"}, 128'(cfg_valid), 128'(exp_valid));
    chk(pump_ratio == exp_bus[2:0], {tag, " R11 pump ratio"}, 128'(pump_ratio), 128'(exp_bus[2:0]));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2);
    ser_clk = 1'b1; #(CLK_PERIOD); ser_clk = 1'b0;
    #(CLK_PERIOD * 2);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(cfg_bus == 0, "R9 latches zero", 128'(cfg_bus), 128'(0));
    chk(cfg_valid == 0, "R9 valid zero", 128'(cfg_valid), 128'(0));
    chk(cfg_upd == 0, "R9 strobe zero", 128'(cfg_upd), 128'(0));

    // R1 R4 R5 R6: sweep every address
    for (int a = 0; a < 16; a++) begin
      logic [16:0] d = 17'h1A5C3 ^ 17'(a * 17'h0B71);
      shift_bits(21, {43'd0, d, 4'(a)});
      commit_check("R1 sweep");
    end

    // R11: every pump code through address 2
    for (int p = 0; p < 8; p++) begin
      shift_bits(21, {43'd0, 14'(p * 14'h123), 3'(p), 4'd2});
      commit_check("R11 pump code");
    end

    // R3: leading extra bits dropped
    shift_bits(25, {39'd0, 4'b1011, 17'h0F0F1, 4'd5});
    commit_check("R3 long frame");
    // R3: short frame keeps older bits
    shift_bits(21, {43'd0, 17'h13579, 4'd0});
    shift_bits(6, {58'd0, 2'b10, 4'd6});
    commit_check("R3 short frame");

    // R2: bit clock toggles with enable high are ignored
    shift_bits(21, {43'd0, 17'h0ACE1, 4'd9});
    commit_check("R2 preload");
    for (int i = 0; i < 5; i++) begin
      ser_data = i[0];
      #SH; ser_clk = 1'b1; #SH; ser_clk = 1'b0;
    end
    shift_bits(4, {60'd0, 4'd3});
    commit_check("R2 idle clocks");

    // R7: commit held while div_safe is low
    div_safe = 1'b0;
    shift_bits(21, {43'd0, 17'h1BEEF, 4'd4});
    begin
      logic seen = 1'b0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (|cfg_upd) seen = 1'b1;
      end
      chk(!seen, "R7 no write while unsafe", 128'(seen), 128'(0));
      chk(cfg_bus == exp_bus, "R7 latch unchanged while unsafe", 128'(cfg_bus), 128'(exp_bus));
    end
    div_safe = 1'b1;
    commit_check("R7 released");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule